// File: doc/BRIEF.md
# Two-Lane Operand Forwarding Selector

This block decides, for every source operand of the two instructions sitting in the DR/E pipeline register, whether the execution units should take the register-file value or a newer result that is still travelling down the pipe. Six result slots are candidates: the E/DF result, the DF/W result and the value being written back in the current cycle, each for both lanes. The last of these lets the register file write and read in the same cycle without split-phase timing, because the selector hands the new value straight to the reader.

Each lane presents four source register numbers together with the raw register-file read data for them. The block returns a select code and the chosen 64-bit value for each of the eight operands. A ninth selector serves the register-jump target calculation, so that a jump through a register never consumes stale data. The block is purely combinational. Stall decisions and the register file itself sit outside it.

Top module: `dual_lane_fwd_sel`

## Requirements
- R1: When no eligible slot matches a nonzero source register, the select code is 0 and the output value equals the register-file input for that operand.
- R2: A slot is eligible when its write enable is 1, its predicate is 1 and its destination equals the source register. The select code is then 1 + 2*stage + lane, with stage E=0, DF=1 and W=2, and the output equals that slot's value.
- R3: Source register 0 is never forwarded. Its select code is 0 and its output value is all zeros, whatever the register-file input and the slots carry.
- R4: When matching slots exist in several stages, the youngest stage wins, in the order E, then DF, then W.
- R5: When both lanes match in the same stage, the lane 1 slot wins over the lane 0 slot.
- R6: A slot flagged as a multiply is eligible only when its stage age is at least MUL_LAT cycles, where E=1, DF=2 and W=3. With the default MUL_LAT=3, only W-stage multiplies forward.
- R7: A slot whose write enable is 0, or whose predicate is 0, has no effect on any selection, even when its destination matches.
- R8: The jump-target selector applies R1 to R7 to its own source register and register-file input. It gives the same select code as any operand selector that sees the same source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lane_src | input | 40 | Source register numbers; operand k (lane*4+index) occupies bits [k*5 +: 5] |
| lane_rf | input | 512 | Register-file read data; operand k occupies bits [k*64 +: 64] |
| prd_we | input | 6 | Write enable per slot; slot s = 2*stage + lane |
| prd_pred | input | 6 | Guarding predicate value per slot |
| prd_mul | input | 6 | Slot holds a multiply result |
| prd_dst | input | 30 | Destination register per slot, [s*5 +: 5] |
| prd_val | input | 384 | Result value per slot, [s*64 +: 64] |
| jmp_src | input | 5 | Source register of the register-jump target |
| jmp_rf | input | 64 | Register-file read data for the jump source |
| opnd_sel | output | 24 | Select code per operand, [k*3 +: 3] |
| opnd_val | output | 512 | Selected value per operand, [k*64 +: 64] |
| jmp_sel | output | 3 | Select code for the jump target |
| jmp_val | output | 64 | Selected jump-target value |

## Verification
Stage priority and multiply readiness can decide the same operand in the same cycle. This happens when a younger slot holds a multiply that is not finished while an older ALU result targets the same register. In that case the older result must win, and a ready multiply in W must still win over nothing. Directed cases set up exactly these collisions. Random cycles then draw register numbers from 0 to 7, so that the register-zero rule also collides often with live slots. A behavioural model in the bench, which walks an ordered queue of slots, judges every selector on every cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int LANES  = 2;
  localparam int STAGES = 3;
  localparam int SLOTS  = LANES * STAGES;
  localparam int SELW   = $clog2(SLOTS + 1);

  // cycles since issue at which a slot's stage holds its result (E=1, DF=2, W=3)
  function automatic int slot_age(input int slot);
    return slot / LANES + 1;
  endfunction

  // priority rank, 0 = strongest: younger stage first, then younger lane
  function automatic int slot_rank(input int slot);
    return (slot / LANES) * LANES + (LANES - 1 - slot % LANES);
  endfunction

  // select code carried for a slot; 0 is kept for the register file
  function automatic int slot_code(input int slot);
    return slot + 1;
  endfunction
endpackage

// File: rtl/producer_qualify.sv
module producer_qualify
  import fwd_pkg::*;
#(
  parameter int MUL_LAT = 3
) (
  input  logic [SLOTS-1:0] we,
  input  logic [SLOTS-1:0] pred,
  input  logic [SLOTS-1:0] is_mul,
  output logic [SLOTS-1:0] live
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (slot_age(g) >= MUL_LAT) begin : g_ready
      assign live[g] = we[g] & pred[g];
    end else begin : g_gate
      assign live[g] = we[g] & pred[g] & ~is_mul[g];
    end
  end
endmodule

// File: rtl/operand_pick.sv
module operand_pick
  import fwd_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int RW   = 5
) (
  input  logic [RW-1:0]         src,
  input  logic [XLEN-1:0]       rf_val,
  input  logic [SLOTS-1:0]      live,
  input  logic [SLOTS*RW-1:0]   dst,
  input  logic [SLOTS*XLEN-1:0] val,
  output logic [SELW-1:0]       sel,
  output logic [XLEN-1:0]       out
);
  logic [SLOTS-1:0] match;

  always_comb begin
    logic hit;
    hit = 1'b0;
    sel = '0;
    out = rf_val;
    for (int s = 0; s < SLOTS; s++)
      match[s] = live[s] && (dst[s*RW +: RW] == src) && (src != '0);
    for (int st = 0; st < STAGES; st++) begin
      for (int ln = LANES - 1; ln >= 0; ln--) begin
        if (match[st*LANES + ln] && !hit) begin
          hit = 1'b1;
          sel = SELW'(slot_code(st*LANES + ln));
          out = val[(st*LANES + ln)*XLEN +: XLEN];
        end
      end
    end
    if (src == '0) out = '0;

    // R3
    if (src == '0) zero_reg_chk: assert (sel == '0 && out == '0);
    // R1
    if (src != '0 && sel == '0) rf_pass_chk: assert (out == rf_val);
    if (sel != '0) begin
      // R2 R7
      eligible_chk: assert (live[int'(sel) - 1] && dst[(int'(sel) - 1)*RW +: RW] == src);
      // R2
      value_chk: assert (out == val[(int'(sel) - 1)*XLEN +: XLEN]);
      // R4 R5
      for (int t = 0; t < SLOTS; t++)
        if (match[t]) youngest_chk: assert (slot_rank(t) >= slot_rank(int'(sel) - 1));
    end else begin
      // R1
      no_match_chk: assert (match == '0);
    end
  end
endmodule

// File: rtl/dual_lane_fwd_sel.sv
module dual_lane_fwd_sel
  import fwd_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int RW      = 5,
  parameter int OPS     = 4,
  parameter int MUL_LAT = 3
) (
  input  logic [LANES*OPS*RW-1:0]   lane_src,
  input  logic [LANES*OPS*XLEN-1:0] lane_rf,
  input  logic [SLOTS-1:0]          prd_we,
  input  logic [SLOTS-1:0]          prd_pred,
  input  logic [SLOTS-1:0]          prd_mul,
  input  logic [SLOTS*RW-1:0]       prd_dst,
  input  logic [SLOTS*XLEN-1:0]     prd_val,
  input  logic [RW-1:0]             jmp_src,
  input  logic [XLEN-1:0]           jmp_rf,
  output logic [LANES*OPS*SELW-1:0] opnd_sel,
  output logic [LANES*OPS*XLEN-1:0] opnd_val,
  output logic [SELW-1:0]           jmp_sel,
  output logic [XLEN-1:0]           jmp_val
);
  localparam int NPICK = LANES * OPS;

  logic [SLOTS-1:0] live;

  producer_qualify #(.MUL_LAT(MUL_LAT)) u_qual (
    .we(prd_we), .pred(prd_pred), .is_mul(prd_mul), .live(live)
  );

  for (genvar k = 0; k < NPICK; k++) begin : g_opnd
    operand_pick #(.XLEN(XLEN), .RW(RW)) u_pick (
      .src(lane_src[k*RW +: RW]), .rf_val(lane_rf[k*XLEN +: XLEN]),
      .live(live), .dst(prd_dst), .val(prd_val),
      .sel(opnd_sel[k*SELW +: SELW]), .out(opnd_val[k*XLEN +: XLEN])
    );
  end

  operand_pick #(.XLEN(XLEN), .RW(RW)) u_jmp (
    .src(jmp_src), .rf_val(jmp_rf), .live(live), .dst(prd_dst), .val(prd_val),
    .sel(jmp_sel), .out(jmp_val)
  );

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      // R6
      if (prd_mul[s] && slot_age(s) < MUL_LAT) mul_wait_chk: assert (!live[s]);
      // R7
      if (!prd_we[s] || !prd_pred[s]) dead_slot_chk: assert (!live[s]);
    end
    // R8
    for (int k = 0; k < NPICK; k++)
      if (lane_src[k*RW +: RW] == jmp_src)
        jmp_agree_chk: assert (jmp_sel == opnd_sel[k*SELW +: SELW]);
  end
endmodule

// File: tb/dual_lane_fwd_sel_bench.sv
module dual_lane_fwd_sel_bench;
  import fwd_pkg::*;
  localparam int XLEN = 64, RW = 5, OPS = 4, MUL_LAT = 3, NP = LANES * OPS;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [RW-1:0]   b_src [NP];
  logic [XLEN-1:0] b_rf  [NP];
  logic [RW-1:0]   b_dst [SLOTS];
  logic [XLEN-1:0] b_val [SLOTS];
  logic [SLOTS-1:0] b_we, b_pred, b_mul;
  logic [RW-1:0]   b_jsrc;
  logic [XLEN-1:0] b_jrf;

  logic [NP*RW-1:0]      src_f;
  logic [NP*XLEN-1:0]    rf_f;
  logic [SLOTS*RW-1:0]   dst_f;
  logic [SLOTS*XLEN-1:0] val_f;
  logic [NP*SELW-1:0]    o_sel;
  logic [NP*XLEN-1:0]    o_val;
  logic [SELW-1:0]       j_sel;
  logic [XLEN-1:0]       j_val;

  for (genvar k = 0; k < NP; k++) begin : g_pk
    assign src_f[k*RW +: RW]     = b_src[k];
    assign rf_f[k*XLEN +: XLEN]  = b_rf[k];
  end
  for (genvar s = 0; s < SLOTS; s++) begin : g_ps
    assign dst_f[s*RW +: RW]     = b_dst[s];
    assign val_f[s*XLEN +: XLEN] = b_val[s];
  end

  dual_lane_fwd_sel #(.XLEN(XLEN), .RW(RW), .OPS(OPS), .MUL_LAT(MUL_LAT)) u_dual_lane_fwd_sel (
    .lane_src(src_f), .lane_rf(rf_f), .prd_we(b_we), .prd_pred(b_pred), .prd_mul(b_mul),
    .prd_dst(dst_f), .prd_val(val_f), .jmp_src(b_jsrc), .jmp_rf(b_jrf),
    .opnd_sel(o_sel), .opnd_val(o_val), .jmp_sel(j_sel), .jmp_val(j_val)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model: walk a queue of (stage,lane) in preference order
  task automatic model(input int src, input logic [XLEN-1:0] rf,
                       output int esel, output logic [XLEN-1:0] eval);
    int order[$];
    esel = 0;
    eval = (src == 0) ? '0 : rf;
    if (src == 0) return;
    for (int st = 0; st < 3; st++) begin
      order.push_back(st * 2 + 1);
      order.push_back(st * 2);
    end
    while (order.size() > 0) begin
      int s;
      s = order.pop_front();
      if (b_we[s] && b_pred[s] && int'(b_dst[s]) == src &&
          (!b_mul[s] || (s / 2 + 1) >= MUL_LAT)) begin
        esel = s + 1;
        eval = b_val[s];
        return;
      end
    end
  endtask

  task automatic compare(input string req, input string what, input int k,
                         input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s[%0d] got %h exp %h", req, what, k, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    int es;
    logic [XLEN-1:0] ev;
    @(negedge clk);
    for (int k = 0; k < NP; k++) begin
      model(int'(b_src[k]), b_rf[k], es, ev);
      compare(req, "sel", k, XLEN'(o_sel[k*SELW +: SELW]), XLEN'(es));
      compare(req, "val", k, o_val[k*XLEN +: XLEN], ev);
    end
    model(int'(b_jsrc), b_jrf, es, ev);
    compare(req == "R4" ? "R8" : req, "jsel", 0, XLEN'(j_sel), XLEN'(es));
    compare(req == "R4" ? "R8" : req, "jval", 0, j_val, ev);
    @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    for (int k = 0; k < NP; k++) begin b_src[k] = '0; b_rf[k] = '0; end
    for (int s = 0; s < SLOTS; s++) begin b_dst[s] = '0; b_val[s] = '0; end
    b_we = '0; b_pred = '0; b_mul = '0; b_jsrc = '0; b_jrf = '0;
  endtask

  task automatic set_slot(input int s, input int dst, input bit mul);
    b_we[s] = 1'b1; b_pred[s] = 1'b1; b_mul[s] = mul;
    b_dst[s] = RW'(dst); b_val[s] = 64'hA000_0000_0000_0000 | 64'(s * 17 + dst);
  endtask

  initial begin
    clear_all();
    @(posedge clk); #1;
    check_all("R1");                       // all-quiet state
    for (int k = 0; k < NP; k++) begin b_src[k] = RW'(k + 1); b_rf[k] = 64'h1111 * 64'(k + 1); end
    check_all("R1");                       // no producers
    set_slot(0, 3, 0);                     // E lane0 writes r3
    set_slot(5, 6, 0);                     // W lane1 writes r6
    b_jsrc = 5'd3; b_jrf = 64'h77;
    check_all("R2");
    clear_all();
    b_src[0] = 5'd0; b_rf[0] = 64'hDEAD; b_src[5] = 5'd0; b_rf[5] = 64'hBEEF;
    set_slot(1, 0, 0); set_slot(4, 0, 0);
    check_all("R3");
    clear_all();
    for (int k = 0; k < NP; k++) begin b_src[k] = 5'd7; b_rf[k] = 64'h5; end
    set_slot(0, 7, 0); set_slot(3, 7, 0); set_slot(4, 7, 0);
    check_all("R4");                       // E wins
    b_we[0] = 1'b0;
    check_all("R4");                       // DF wins
    set_slot(2, 7, 0);
    check_all("R5");                       // DF lane1 over DF lane0
    clear_all();
    for (int k = 0; k < NP; k++) begin b_src[k] = 5'd9; b_rf[k] = 64'h9; end
    set_slot(0, 9, 0); set_slot(1, 9, 0);
    check_all("R5");                       // E lane1 over E lane0
    clear_all();
    for (int k = 0; k < NP; k++) begin b_src[k] = 5'd4; b_rf[k] = 64'h44; end
    b_jsrc = 5'd4; b_jrf = 64'h45;
    set_slot(1, 4, 1); set_slot(2, 4, 1); set_slot(4, 4, 0);
    check_all("R6");                       // unfinished multiplies skipped, W ALU wins
    b_we[4] = 1'b0; set_slot(5, 4, 1);
    check_all("R6");                       // finished multiply in W forwards
    clear_all();
    for (int k = 0; k < NP; k++) begin b_src[k] = 5'd12; b_rf[k] = 64'hC; end
    set_slot(0, 12, 0); b_pred[0] = 1'b0;
    set_slot(3, 12, 0); b_we[3] = 1'b0;
    check_all("R7");                       // both dead, register file used
    b_jsrc = 5'd12; b_jrf = 64'hCC; b_pred[0] = 1'b1;
    check_all("R8");
    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < NP; k++) begin
        b_src[k] = RW'($urandom_range(0, 7)); b_rf[k] = {$urandom, $urandom};
      end
      for (int s = 0; s < SLOTS; s++) begin
        b_dst[s] = RW'($urandom_range(0, 7)); b_val[s] = {$urandom, $urandom};
      end
      b_we = SLOTS'($urandom); b_pred = SLOTS'($urandom); b_mul = SLOTS'($urandom);
      b_jsrc = RW'($urandom_range(0, 7)); b_jrf = {$urandom, $urandom};
      check_all("R4");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule